// File: doc/BRIEF.md
# Data-Strobe Link Repeater

This block terminates one hop of a serial link that carries a data line and a strobe line. Exactly one of the two lines changes for every bit. The block oversamples both lines with a fast system clock and treats any change on either line as the arrival of a new bit, whose value is the level of the data line. Each recovered bit is handed to the local packet logic with a one-cycle valid strobe, in arrival order.

The same stream is sent on to the next device in a chain through a downstream data/strobe pair. The pair uses the same encoding, and the stream it carries trails the received stream by two bits. An outgoing bit is launched only when an incoming edge arrives. If the upstream side stops toggling, the downstream side holds its current levels. After reset the first two bits sent downstream are zero fillers that carry no data. To push the last bit of a packet through N chained stages, the sender follows the packet with 2×N further bits, normally as a dummy packet that no device acts on.

With the default two-flop synchronizer and a 250 MHz system clock, input edges must be at least three clock cycles apart. A 20 Mbit/s link gives 12.5 cycles per bit. The upstream lines are expected to be low while reset is asserted.

Top module: `ds_link_repeater`

## Requirements
- R1: While rst_n is low at a rising clock edge, ds_data_out, ds_strobe_out and bit_valid are all low after that edge.
- R2: A change on either input line produces a bit_valid pulse of exactly one cycle. During that pulse bit_out equals the level of ds_data_in after the change.
- R3: Every input edge launches one output bit. The bit launched on the k-th edge after reset is the bit recovered on edge k-2, giving a two-bit lag.
- R4: The bits launched on the first two input edges after reset are fillers of value 0.
- R5: The output pair is data-strobe encoded. On each launch ds_data_out takes the launched bit, and ds_strobe_out toggles exactly when that bit equals the previous ds_data_out. Exactly one output line changes per launch.
- R6: While neither input line changes, both output lines hold their levels and bit_valid stays low.
- R7: A reset in mid-stream clears the two-bit history, so filler bits appear again on the next two input edges.
- R8: Two stages in series deliver the recovered stream with a four-bit lag at the far end, still data-strobe encoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ds_data_in | input | 1 | Upstream data line |
| ds_strobe_in | input | 1 | Upstream strobe line |
| ds_data_out | output | 1 | Downstream data line |
| ds_strobe_out | output | 1 | Downstream strobe line |
| bit_out | output | 1 | Recovered bit for the local packet side |
| bit_valid | output | 1 | One-cycle strobe marking bit_out as new |

## Verification
A change on an input line reaches bit_valid, bit_out and the downstream pair on the third rising clock edge after it is driven. The changed value passes two synchronizer flops and then the registered output stage. A second stage in series shows its result three edges after that. Each bit is driven on a falling edge, and the bench counts exactly three rising edges before it samples the first stage. It checks that bit_valid is low again one edge later and samples the second stage on the sixth edge. All samples are taken 1 ns after an edge. The idle and reset tests sample at that same offset over many cycles.

// File: rtl/ds_link_pkg.sv
// Shared types and limits for the data-strobe link repeater.
// Assumes: a link bit is carried on one data and one strobe line.
package ds_link_pkg;
    typedef struct packed {
        logic dat;
        logic stb;
    } ds_pair_t;

    localparam int MIN_SYNC_STAGES = 2;
    localparam int MIN_LAG_BITS    = 2;
endpackage

// File: rtl/ds_line_sync.sv
// Brings both upstream link lines into the clk domain.
// Assumes: lines are low while reset is held; STAGES >= 2.
module ds_line_sync
    import ds_link_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  ds_pair_t line_in,
    output ds_pair_t line_sync
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;

    assign raw = {line_in.dat, line_in.stb};

    generate
        for (genvar i = 0; i < NLINES; i++) begin : g_line
            logic [STAGES-1:0] chain;
            // Shift one line through its synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], raw[i]};
            end
            assign synced[i] = chain[STAGES-1];
        end
    endgenerate

    assign line_sync.dat = synced[1];
    assign line_sync.stb = synced[0];
endmodule

// File: rtl/ds_bit_recover.sv
// Detects a change on either synchronized line and recovers the bit.
// Assumes: successive line changes are at least three clk cycles apart.
module ds_bit_recover
    import ds_link_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ds_pair_t line_sync,
    output logic     edge_seen,
    output logic     new_bit,
    output logic     bit_out,
    output logic     bit_valid
);
    ds_pair_t prev;

    assign edge_seen = (line_sync.dat ^ prev.dat) | (line_sync.stb ^ prev.stb);
    assign new_bit   = line_sync.dat;

    // Remember last sampled levels and register the recovered bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev      <= '0;
            bit_out   <= 1'b0;
            bit_valid <= 1'b0;
        end else begin
            prev      <= line_sync;
            bit_valid <= edge_seen;
            if (edge_seen) bit_out <= new_bit;
        end
    end

    // R2
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);
endmodule

// File: rtl/ds_lag_encoder.sv
// Holds the last LAG_BITS recovered bits and launches the oldest one on the
// downstream pair, data-strobe encoded, once per input edge.
// Assumes: LAG_BITS >= 2; history resets to zero so the first launches are fillers.
module ds_lag_encoder #(
    parameter int LAG_BITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic new_bit,
    output logic out_dat,
    output logic out_stb
);
    localparam int CNT_W = $clog2(LAG_BITS + 1);

    logic [LAG_BITS-1:0] hist;
    logic                send_bit;

    assign send_bit = hist[LAG_BITS-1];

    // Shift history and re-encode the oldest bit on each launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist    <= '0;
            out_dat <= 1'b0;
            out_stb <= 1'b0;
        end else if (launch) begin
            hist    <= {hist[LAG_BITS-2:0], new_bit};
            out_dat <= send_bit;
            if (send_bit == out_dat) out_stb <= ~out_stb;
        end
    end

    // Saturating launch count since reset, used only by the filler check.
    logic [CNT_W-1:0] launches;
    always_ff @(posedge clk) begin
        if (!rst_n)                                    launches <= '0;
        else if (launch && launches < CNT_W'(LAG_BITS)) launches <= launches + 1'b1;
    end

    // R4
    filler_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && launches < CNT_W'(LAG_BITS)) |=> !out_dat);

    // R5
    one_line_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({out_dat ^ $past(out_dat), out_stb ^ $past(out_stb)}) <= 1);
endmodule

// File: rtl/ds_link_repeater.sv
// One hop of a data-strobe link: recovers bits for local use and repeats the
// stream downstream with a fixed lag, advancing only on input edges.
// Assumes: upstream idles low during reset; edges >= 3 clk cycles apart.
module ds_link_repeater
    import ds_link_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LAG_BITS    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ds_data_in,
    input  logic ds_strobe_in,
    output logic ds_data_out,
    output logic ds_strobe_out,
    output logic bit_out,
    output logic bit_valid
);
    ds_pair_t line_in;
    ds_pair_t line_sync;
    logic     edge_seen;
    logic     new_bit;

    assign line_in.dat = ds_data_in;
    assign line_in.stb = ds_strobe_in;

    ds_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .line_sync (line_sync)
    );

    ds_bit_recover u_recover (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_sync (line_sync),
        .edge_seen (edge_seen),
        .new_bit   (new_bit),
        .bit_out   (bit_out),
        .bit_valid (bit_valid)
    );

    ds_lag_encoder #(.LAG_BITS(LAG_BITS)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (edge_seen),
        .new_bit (new_bit),
        .out_dat (ds_data_out),
        .out_stb (ds_strobe_out)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (!ds_data_out && !ds_strobe_out && !bit_valid));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |-> $stable({ds_data_out, ds_strobe_out}));

    // R5
    launch_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> ({ds_data_out, ds_strobe_out} != $past({ds_data_out, ds_strobe_out})));
endmodule

// File: tb/ds_link_repeater_test.sv
// Directed bench: one stage (uut) feeding a second stage (stage2).
module ds_link_repeater_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0, sin = 1'b0;
    logic d1, s1, b1, v1;
    logic d2, s2, b2, v2;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [511:0] sent;
    int  n;
    logic e1d, e1s, e2d, e2s;

    always #2 clk = ~clk;

    ds_link_repeater uut (
        .clk(clk), .rst_n(rst_n), .ds_data_in(din), .ds_strobe_in(sin),
        .ds_data_out(d1), .ds_strobe_out(s1), .bit_out(b1), .bit_valid(v1));

    ds_link_repeater stage2 (
        .clk(clk), .rst_n(rst_n), .ds_data_in(d1), .ds_strobe_in(s1),
        .ds_data_out(d2), .ds_strobe_out(s2), .bit_out(b2), .bit_valid(v2));

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        n = 0; sent = '0;
        e1d = 0; e1s = 0; e2d = 0; e2s = 0;
    endtask

    // R1, R7: hold reset, check cleared outputs
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; din = 1'b0; sin = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk("R1", "data_out", d1, 1'b0);
        chk("R1", "strobe_out", s1, 1'b0);
        chk("R1", "bit_valid", v1, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    // Send one bit, predict both stages, check each at its due cycle.
    task automatic send_bit(input logic b);
        logic lb1, lb2;
        @(negedge clk);
        if (b != din) din = b; else sin = ~sin;
        sent[n] = b;
        lb1 = (n < 2) ? 1'b0 : sent[n-2];
        lb2 = (n < 4) ? 1'b0 : sent[n-4];
        if (lb1 != e1d) e1d = lb1; else e1s = ~e1s;
        if (lb2 != e2d) e2d = lb2; else e2s = ~e2s;
        repeat (3) @(posedge clk);
        #1;
        chk("R2", "bit_valid", v1, 1'b1);
        chk("R2", "bit_out", b1, b);
        if (n < 2) chk("R4", "filler", d1, 1'b0);
        chk("R3", "data_out", d1, e1d);
        chk("R5", "strobe_out", s1, e1s);
        @(posedge clk);
        #1;
        chk("R2", "valid_drop", v1, 1'b0);
        repeat (2) @(posedge clk);
        #1;
        chk("R8", "chain_valid", v2, 1'b1);
        chk("R8", "chain_data", d2, e2d);
        chk("R8", "chain_strobe", s2, e2s);
        repeat (2) @(posedge clk);
        n++;
    endtask

    task automatic test_alternating();
        for (int i = 0; i < 10; i++) send_bit(i[0]);
    endtask

    task automatic test_runs();
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        for (int i = 0; i < 6; i++) send_bit(1'b0);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    endtask

    // R6: no input movement, nothing moves
    task automatic test_idle();
        logic hd, hs;
        #1; hd = d1; hs = s1;
        for (int i = 0; i < 24; i++) begin
            @(posedge clk); #1;
            chk("R6", "hold_data", d1, hd);
            chk("R6", "hold_strobe", s1, hs);
            chk("R6", "no_valid", v1, 1'b0);
        end
    endtask

    // R7: reset mid-stream, fillers reappear
    task automatic test_midreset();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        do_reset();
        chk("R7", "cleared", d1, 1'b0);
        send_bit(1'b1);
        chk("R7", "filler1", d1, 1'b0);
        send_bit(1'b1);
        chk("R7", "filler2", d1, 1'b0);
        send_bit(1'b0);
        chk("R7", "first_real", d1, 1'b1);
    endtask

    initial begin
        model_clear();
        do_reset();
        test_alternating();
        test_idle();
        test_runs();
        test_idle();
        test_midreset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule